// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that looks like a small serial EEPROM to a bus controller. A fast system clock oversamples the SCL and SDA wires. The block drives SDA only by pulling it low, through an open-drain enable output. It recognises START and STOP conditions and checks the control byte. Write data is collected into a 16-byte page buffer. The buffer is copied into a 512-byte on-chip array once the transaction ends. The block serves random reads, current-address reads and sequential reads from the same array.

Storage is two 256-byte blocks. One bit of the control byte selects the block, and the 8-bit word address that follows selects a byte inside it. A write-protect input lets a controller run a write transaction that leaves the array untouched. After each committed write, the target stays busy for a fixed number of system clocks. While busy, it refuses its control byte, so a controller can poll for completion.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `sda_oe` is low.
- R2: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) abandons any partly received byte. A write cut short this way, before any data byte completes, changes no memory location and starts no busy time.
- R3: The control byte is taken MSB first. Bits [7:4] must be 1010. Bits [3:2] are ignored, bit 1 is the block select and bit 0 is the direction (0 = write, 1 = read). If bits [7:4] are anything else, the byte gets no acknowledge, and the target keeps `sda_oe` low until the next START.
- R4: To acknowledge a received byte, the target holds SDA low for the whole high phase of the 9th SCL pulse. It changes `sda_oe` only while the synchronized SCL is low.
- R5: In a write, the byte after the control byte is the word address. Block select and word address together form the 9-bit location {block, word}.
- R6: Each write data byte goes to the current location. Only the low 4 location bits then advance, wrapping inside the 16-byte page, so bytes beyond the 16th overwrite the earliest ones written to that page.
- R7: A write's data bytes are committed to the array only on a STOP that directly ends that write transaction. A START resets the buffer when the target is not busy. A commit starts a busy time of `WRITE_CYCLES` clocks, during which a valid control byte is not acknowledged.
- R8: With `wp_in` high at the STOP, the write data bytes are still acknowledged, but the array is unchanged and no busy time starts.
- R9: A read that has no address phase starts from the location after the last one accessed. After a write, that is the next location in the page (wrapping). After a read, it is the next of the 512 locations (wrapping). The block-select bit of a read control byte is ignored.
- R10: A read continues through consecutive locations, crossing from block 0 into block 1, for as long as the controller acknowledges. A NACK makes the target release SDA and wait for a STOP or START.
- R11: Data bytes are shifted MSB first in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL wire level |
| sda_in | input | 1 | Sampled SDA wire level |
| wp_in | input | 1 | Write protect; high blocks array updates |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
Random page writes of 1 to 18 bytes, at random block, address and don't-care control bits, each followed by a random read of the same area. Writes longer than 16 bytes separate correct page wrapping from a plain incrementing address. Directed cases add:
- a read that crosses the block boundary, which separates the 9-bit read pointer from the 8-bit word address;
- identical word addresses in both blocks, which exposes an ignored block-select bit;
- a bad control tag, a poll while busy, and a write under write protect;
- a write cut short by a STOP in the middle of a byte;
- current-address reads after both writes and reads, which separate the two pointer rules.

// File: rtl/i2ct_pkg.sv
// Shared constants and types for the I2C EEPROM target.
// Assumes a 512-byte array made of two 256-byte blocks.
package i2ct_pkg;
    localparam int MEM_BYTES = 512;
    localparam int ADDR_W    = $clog2(MEM_BYTES);
    localparam logic [3:0] CTRL_TAG = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_WAIT
    } eng_state_t;

    typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA} rx_kind_t;
endpackage

// File: rtl/i2ct_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and flags edges
// and bus conditions on the synchronized samples.
// Assumes the idle bus level is high on both wires.
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    // Shift both wires through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_in};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];
    assign scl_q = scl_pipe[STAGES];
    assign sda_q = sda_pipe[STAGES];

    // Edge and condition decode, one cycle after the sample.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2ct_engine.sv
// Bit and byte sequencer of the target: receives control, address and data
// bytes, sends read bytes, and drives the open-drain enable.
// Assumes edge flags come from synchronized samples, one clock wide.
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    input  logic [7:0]        rd_byte,
    output logic              sda_oe,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_val,
    output logic              wr_push,
    output logic [7:0]        wr_byte,
    output logic              rd_adv
);
    eng_state_t st;
    rx_kind_t   kind;
    logic [3:0] bitc;
    logic [7:0] shreg, txs;
    logic       rw, blk, mack;

    // Main sequencer: one action per synchronized SCL edge or bus condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; kind <= K_CTRL; bitc <= '0; shreg <= '0; txs <= '0;
            rw <= 1'b0; blk <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
            addr_load <= 1'b0; addr_val <= '0; wr_push <= 1'b0; wr_byte <= '0;
            rd_adv <= 1'b0;
        end else begin
            addr_load <= 1'b0;
            wr_push   <= 1'b0;
            rd_adv    <= 1'b0;
            if (start_det) begin
                st <= ST_RX; kind <= K_CTRL; bitc <= '0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                st <= ST_IDLE; bitc <= '0; sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            bitc  <= bitc + 4'd1;
                        end else if (scl_fall && bitc == 4'd8) begin
                            case (kind)
                                K_CTRL: begin
                                    if (shreg[7:4] == CTRL_TAG && !busy) begin
                                        rw <= shreg[0]; blk <= shreg[1];
                                        sda_oe <= 1'b1; st <= ST_RXACK;
                                    end else begin
                                        st <= ST_WAIT;
                                    end
                                end
                                K_ADDR: begin
                                    addr_load <= 1'b1; addr_val <= {blk, shreg};
                                    sda_oe <= 1'b1; st <= ST_RXACK;
                                end
                                default: begin
                                    wr_push <= 1'b1; wr_byte <= shreg;
                                    sda_oe <= 1'b1; st <= ST_RXACK;
                                end
                            endcase
                        end
                    end
                    ST_RXACK: begin
                        if (scl_fall) begin
                            bitc <= '0;
                            if (kind == K_CTRL && rw) begin
                                st <= ST_TX; txs <= rd_byte; sda_oe <= ~rd_byte[7];
                            end else begin
                                st <= ST_RX; sda_oe <= 1'b0;
                                kind <= (kind == K_CTRL) ? K_ADDR : K_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitc <= bitc + 4'd1;
                        end else if (scl_fall) begin
                            if (bitc == 4'd8) begin
                                sda_oe <= 1'b0; rd_adv <= 1'b1; st <= ST_TXACK;
                            end else begin
                                txs <= {txs[6:0], 1'b0}; sda_oe <= ~txs[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                st <= ST_TX; bitc <= '0; txs <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);
    // R3
    nack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> !sda_oe);
    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RXACK && scl_s) |-> sda_oe);
    // R7
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RXACK && kind == K_CTRL) |-> !busy);
endmodule

// File: rtl/i2ct_store.sv
// Location pointer, page buffer, 512-byte array and write busy timer.
// Assumes WRITE_CYCLES exceeds PAGE_BYTES, so the commit walk ends inside
// the timed busy window, and that no transfer is accepted while busy.
module i2ct_store
    import i2ct_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              wr_push,
    input  logic [7:0]        wr_byte,
    input  logic              rd_adv,
    output logic [7:0]        rd_byte,
    output logic              busy
);
    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic [ADDR_W-1:0]     ptr;
    logic [BUSY_W-1:0]     busy_cnt;
    logic [PG_W:0]         cidx;
    logic                  walking, commit_go, mem_we;

    assign walking   = ~cidx[PG_W];
    assign busy      = (busy_cnt != '0) | walking;
    assign commit_go = stop_det & (|pvalid) & ~wp & ~busy;
    assign mem_we    = walking & pvalid[cidx[PG_W-1:0]];

    // Location pointer: load, page-wrapped write advance, linear read advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr <= '0;
        else if (addr_load) ptr <= addr_val;
        else if (wr_push)   ptr <= {ptr[ADDR_W-1:PG_W], ptr[PG_W-1:0] + PG_W'(1)};
        else if (rd_adv)    ptr <= ptr + ADDR_W'(1);
    end

    // Page buffer data, indexed by the low pointer bits.
    always_ff @(posedge clk) begin
        if (wr_push) pbuf[ptr[PG_W-1:0]] <= wr_byte;
    end

    // Valid mask: cleared by an idle START or at the end of the commit walk.
    always_ff @(posedge clk) begin
        if (!rst_n)                            pvalid <= '0;
        else if (start_det && !busy)           pvalid <= '0;
        else if (walking && cidx[PG_W-1:0] == PG_W'(PAGE_BYTES - 1)) pvalid <= '0;
        else if (wr_push)                      pvalid[ptr[PG_W-1:0]] <= 1'b1;
    end

    // Busy timer, loaded on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_cnt <= '0;
        else if (commit_go)        busy_cnt <= BUSY_W'(WRITE_CYCLES);
        else if (busy_cnt != '0)   busy_cnt <= busy_cnt - BUSY_W'(1);
    end

    // Commit walk index, one page slot per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)         cidx <= (PG_W + 1)'(PAGE_BYTES);
        else if (commit_go) cidx <= '0;
        else if (walking)   cidx <= cidx + (PG_W + 1)'(1);
    end

    // Array write port and registered read port.
    always_ff @(posedge clk) begin
        if (mem_we) mem[{ptr[ADDR_W-1:PG_W], cidx[PG_W-1:0]}] <= pbuf[cidx[PG_W-1:0]];
        rd_byte <= mem[ptr];
    end

    // R7
    mem_wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy_cnt != '0));
    // R6
    page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_push |=> (ptr[ADDR_W-1:PG_W] == $past(ptr[ADDR_W-1:PG_W])));
    // R8
    wp_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && wp && !busy) |=> !busy);
endmodule

// File: rtl/i2c_eeprom_target.sv
// Top of the I2C EEPROM target: synchronizer, sequencer and storage.
// Assumes clk runs at least about 20 times faster than SCL.
module i2c_eeprom_target
    import i2ct_pkg::*;
#(
    parameter int WRITE_CYCLES = 1000,
    parameter int PAGE_BYTES   = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wp_in,
    output logic sda_oe
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, addr_load, wr_push, rd_adv;
    logic [ADDR_W-1:0] addr_val;
    logic [7:0] wr_byte, rd_byte;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2ct_engine u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .busy(busy), .rd_byte(rd_byte), .sda_oe(sda_oe),
        .addr_load(addr_load), .addr_val(addr_val), .wr_push(wr_push),
        .wr_byte(wr_byte), .rd_adv(rd_adv)
    );

    i2ct_store #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .wp(wp_in), .start_det(start_det),
        .stop_det(stop_det), .addr_load(addr_load), .addr_val(addr_val),
        .wr_push(wr_push), .wr_byte(wr_byte), .rd_adv(rd_adv),
        .rd_byte(rd_byte), .busy(busy)
    );

    // R4
    oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
    localparam int Q  = 8;
    localparam int WC = 1000;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    i2c_eeprom_target #(.WRITE_CYCLES(WC)) i_i2c_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .wp_in(wp), .sda_oe(sda_oe)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    logic [7:0] ref_mem [512];
    bit         ref_ok  [512];
    int         ref_ptr = 0;
    logic [7:0] wbuf [32];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tq(); repeat (Q) @(negedge clk); endtask

    task automatic m_start();
        sda_m = 1'b1; tq(); scl = 1'b1; tq(); sda_m = 1'b0; tq(); scl = 1'b0; tq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tq(); scl = 1'b1; tq(); sda_m = 1'b1; tq();
    endtask

    task automatic m_bit_out(input logic b);
        sda_m = b; tq(); scl = 1'b1; tq(); tq(); scl = 1'b0; tq();
    endtask

    task automatic m_bit_in(output logic b);
        sda_m = 1'b1; tq(); scl = 1'b1; tq(); b = sda_line; tq(); scl = 1'b0; tq();
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
        m_bit_in(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(input logic nack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin m_bit_in(b); d[i] = b; end
        m_bit_out(nack);
    endtask

    function automatic int page_next(input int p);
        return (p & ~15) | ((p + 1) & 15);
    endfunction

    // Write n bytes of wbuf at {blk,addr}; optionally wait out the busy time.
    task automatic do_write(input int blk, input int addr, input int n,
                            input int dc, input bit wait_busy);
        logic a; int p;
        m_start();
        m_wbyte(8'(8'hA0 | (dc << 2) | (blk << 1)), a); chk("R4 ctrl ack", a, 1);
        m_wbyte(8'(addr), a); chk("R5 word address ack", a, 1);
        p = blk * 256 + addr;
        for (int i = 0; i < n; i++) begin
            m_wbyte(wbuf[i], a); chk("R6 data ack", a, 1);
            if (!wp) begin ref_mem[p] = wbuf[i]; ref_ok[p] = 1'b1; end
            p = page_next(p);
        end
        ref_ptr = p;
        m_stop();
        if (wait_busy && n > 0 && !wp) repeat (WC + 50) @(negedge clk);
    endtask

    // Read n bytes; random mode sets the location first.
    task automatic do_read(input bit rnd, input int blk, input int addr,
                           input int n, input string req);
        logic a; logic [7:0] d;
        if (rnd) begin
            m_start();
            m_wbyte(8'(8'hA0 | (blk << 1)), a); chk("R3 ctrl ack", a, 1);
            m_wbyte(8'(addr), a); chk("R5 address ack", a, 1);
            ref_ptr = blk * 256 + addr;
        end
        m_start();
        m_wbyte(8'(8'hA1 | (blk << 1)), a); chk("R9 read ctrl ack", a, 1);
        for (int i = 0; i < n; i++) begin
            m_rbyte(i == n - 1, d);
            if (ref_ok[ref_ptr]) chk(req, d, ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) % 512;
        end
        repeat (4) @(negedge clk);
        chk("R10 release after NACK", sda_oe, 0);
        m_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a; int blk, addr, n;
        void'($urandom(32'd7315));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 reset sda_oe", sda_oe, 0);
        repeat (40) @(negedge clk);
        chk("R1 idle sda_oe", sda_oe, 0);

        // R6 page wrap with 20 bytes starting mid-page
        for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h30 + i);
        do_write(0, 8'h23, 20, 0, 1'b1);
        do_read(1'b0, 0, 0, 1, "R9 current after write");
        do_read(1'b1, 0, 8'h20, 16, "R6 R11 wrapped page data");
        do_read(1'b0, 1, 0, 2, "R9 current after read");

        // R5 block select: same word in both blocks
        wbuf[0] = 8'h5A; do_write(1, 8'h40, 1, 0, 1'b1);
        wbuf[0] = 8'hA5; do_write(0, 8'h40, 1, 0, 1'b1);
        do_read(1'b1, 1, 8'h40, 1, "R5 block 1 byte");
        do_read(1'b1, 0, 8'h40, 1, "R5 block 0 byte");

        // R10 sequential read across the block boundary
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; do_write(0, 8'hFE, 2, 0, 1'b1);
        wbuf[0] = 8'h33; wbuf[1] = 8'h44; do_write(1, 8'h00, 2, 0, 1'b1);
        do_read(1'b1, 0, 8'hFE, 4, "R10 boundary read");

        // R3 bad control tag, then silence for the rest of the frame
        m_start();
        m_wbyte(8'h50, a); chk("R3 bad tag nack", a, 0);
        m_wbyte(8'hFF, a); chk("R3 silent after nack", a, 0);
        m_stop();

        // R7 poll during busy is refused, then accepted after the timer
        wbuf[0] = 8'h77; do_write(0, 8'h80, 1, 0, 1'b0);
        m_start(); m_wbyte(8'hA0, a); chk("R7 nack while busy", a, 0); m_stop();
        repeat (WC + 50) @(negedge clk);
        m_start(); m_wbyte(8'hA0, a); chk("R7 ack after busy", a, 1); m_stop();
        do_read(1'b1, 0, 8'h80, 1, "R7 committed byte");

        // R8 write protect: acked, no busy, array kept
        wp = 1'b1;
        wbuf[0] = 8'hEE; wbuf[1] = 8'hDD; wbuf[2] = 8'hCC;
        do_write(0, 8'h24, 3, 0, 1'b0);
        m_start(); m_wbyte(8'hA0, a); chk("R8 no busy under wp", a, 1); m_stop();
        wp = 1'b0;
        do_read(1'b1, 0, 8'h24, 3, "R8 array unchanged");

        // R2 STOP in the middle of a data byte
        wbuf[0] = 8'h9C; do_write(0, 8'h60, 1, 0, 1'b1);
        m_start();
        m_wbyte(8'hA0, a); chk("R2 ctrl ack", a, 1);
        m_wbyte(8'h60, a); chk("R2 addr ack", a, 1);
        for (int i = 0; i < 4; i++) m_bit_out(1'b0);
        m_stop();
        m_start(); m_wbyte(8'hA0, a); chk("R2 no busy after abort", a, 1); m_stop();
        do_read(1'b1, 0, 8'h60, 1, "R2 location kept");

        // Random page writes with don't-care bits, read back
        for (int k = 0; k < 7; k++) begin
            blk  = int'($urandom_range(0, 1));
            addr = int'($urandom_range(0, 255));
            n    = int'($urandom_range(1, 18));
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(blk, addr, n, int'($urandom_range(0, 3)), 1'b1);
            do_read(1'b1, blk, addr & 8'hF0, 16, "R6 R11 random page");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule